// File: doc/BRIEF.md
# Single-Leg Switching-Instant Gate Sequencer

This block drives the twelve gate signals of three series-connected H-bridge cells, with two legs per cell and two switches per leg. Once per sampling period an upstream modulator hands it a command with three fields: which cell should move, the ternary level that cell should take (negative, zero or positive), and the clock count into the period at which the move happens. The block captures the command on the sampling tick and runs a period timer. When the timer reaches the requested instant, it moves exactly one leg of that cell. Every other cell keeps its gates.

The zero level can be built two ways: both upper switches on, or both lower switches on. The block uses this freedom to pick the leg. When a cell drops to zero from a non-zero level, the leg that did not move on that cell's previous commutation is the one that moves now. Over time each device therefore switches at half the rate of its cell. A leg that toggles has both of its switches held off for a programmable dead time before the complementary switch turns on. A command that would need two leg moves, or that is malformed, is refused and an error flag is raised.

Top module: `hb_leg_sequencer`

## Requirements
- R1: After reset every cell is at level zero with both lower switches on (per-cell gate nibble 4'b1010), `cell_state` is all zeros and `cmd_err` is low.
- R2: Per cell, gate bit 0 is leg A upper, bit 1 leg A lower, bit 2 leg B upper, bit 3 leg B lower. Positive level is A-upper with B-lower (4'b1001). Negative level is A-lower with B-upper (4'b0110). Zero is 4'b1010 or 4'b0101. `cell_state` codes each cell as 2'b00 for zero, 2'b01 for positive and 2'b11 for negative.
- R3: A command is captured on the clock edge where `tick` is high. Its leg starts to move on the (instant+1)-th rising edge after that capture edge. An instant of 0 therefore acts on the first edge of the period.
- R4: When a leg toggles, both of its switches are off for `dead_time` clock cycles, and then the switch of the new position turns on. With `dead_time` equal to 0 the change is immediate.
- R5: An accepted command changes exactly one leg of the addressed cell. The gates of the other cells do not change.
- R6: When a cell moves from a non-zero level to zero, the leg that toggles is the one that did not toggle on that cell's previous commutation.
- R7: When a cell leaves zero, the leg is forced. From both-lower, positive moves leg A and negative moves leg B. From both-upper, positive moves leg B and negative moves leg A.
- R8: A direct positive-to-negative or negative-to-positive request, a requested code of 2'b10, or a cell index of 3 or more is refused. No gate changes, and `cmd_err` is high from the capture edge until the next tick.
- R9: A request for the level the cell already holds changes nothing and does not raise `cmd_err`.
- R10: The upper and lower switches of one leg are never on together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Sampling-period start strobe; captures the command |
| cmd_cell | input | 2 | Index of the cell to move |
| cmd_state | input | 2 | Requested level code (00 zero, 01 positive, 11 negative) |
| cmd_instant | input | 16 | Clock count into the period at which the leg moves |
| dead_time | input | 8 | Cycles both switches of a toggling leg stay off |
| gate | output | 12 | Gate drives, four bits per cell, cell 0 in the low nibble |
| cell_state | output | 6 | Present level code per cell, cell 0 in the low bits |
| cmd_err | output | 1 | The last captured command was refused |

## Verification
The bench walks the zero state back and forth on the same cell to check that the moving leg alternates. A design that always picked the same leg would show the wrong zero configuration in the gate nibble. It drives the refused cases (a level jump of two steps, the unused code, an out-of-range cell) and then checks that all gates stay put. A design that clamped or partly executed such a command would move a leg. It samples the gates cycle by cycle around the instant and through the dead time, with a non-zero dead time, a zero dead time and an instant of zero, so that an off-by-one timer or a missing dead-time gap shows up as a gate changing one cycle early or late.

// File: rtl/hbseq_pkg.sv
package hbseq_pkg;

  typedef enum logic [1:0] {
    LVL_ZERO = 2'b00,
    LVL_POS  = 2'b01,
    LVL_BAD  = 2'b10,
    LVL_NEG  = 2'b11
  } level_e;

  localparam logic LEG_A = 1'b0;
  localparam logic LEG_B = 1'b1;

  // Level held by a cell given its leg positions (1 = upper switch on).
  function automatic level_e legs_to_level(input logic up_a, input logic up_b);
    if (up_a && !up_b)      return LVL_POS;
    else if (!up_a && up_b) return LVL_NEG;
    else                    return LVL_ZERO;
  endfunction

endpackage

// File: rtl/hbseq_timer.sv
module hbseq_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          load,
  input  logic [TW-1:0] instant,
  output logic          fire
);

  localparam logic [TW-1:0] TMAX = {TW{1'b1}};

  logic [TW-1:0] tmr_q, tmr_d;
  logic [TW-1:0] inst_q, inst_d;
  logic          pend_q, pend_d;

  assign fire = pend_q && (tmr_q == inst_q);

  always_comb begin
    tmr_d  = tmr_q;
    inst_d = inst_q;
    pend_d = pend_q;
    if (tick) begin
      tmr_d  = '0;
      inst_d = instant;
      pend_d = load;
    end else begin
      if (tmr_q != TMAX) tmr_d = tmr_q + 1'b1;
      if (fire)          pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q  <= '0;
      inst_q <= '0;
      pend_q <= 1'b0;
    end else begin
      tmr_q  <= tmr_d;
      inst_q <= inst_d;
      pend_q <= pend_d;
    end
  end

endmodule

// File: rtl/hbseq_cmd_check.sv
module hbseq_cmd_check
  import hbseq_pkg::*;
#(
  parameter int NCELL = 3,
  parameter int CW    = 2
) (
  input  logic [CW-1:0]    cmd_cell,
  input  logic [1:0]       cmd_state,
  input  logic [NCELL-1:0] up_a,
  input  logic [NCELL-1:0] up_b,
  input  logic [NCELL-1:0] last_leg,
  output logic             reject,
  output logic             load,
  output logic             leg
);

  localparam logic [CW:0] NCELL_W = (CW+1)'(NCELL);

  logic          in_range;
  logic [CW-1:0] idx;
  logic          sa, sb, sl;
  level_e        cur, req;

  assign in_range = ({1'b0, cmd_cell} < NCELL_W);
  assign idx      = in_range ? cmd_cell : '0;
  assign sa       = up_a[idx];
  assign sb       = up_b[idx];
  assign sl       = last_leg[idx];
  assign cur      = legs_to_level(sa, sb);
  assign req      = level_e'(cmd_state);

  always_comb begin
    reject = 1'b0;
    load   = 1'b0;
    leg    = LEG_A;
    if (!in_range || req == LVL_BAD) begin
      reject = 1'b1;
    end else if (req == cur) begin
      load = 1'b0;
    end else if (cur != LVL_ZERO && req != LVL_ZERO) begin
      reject = 1'b1;
    end else if (cur == LVL_ZERO) begin
      load = 1'b1;
      if (req == LVL_POS) leg = sa ? LEG_B : LEG_A;
      else                leg = sa ? LEG_A : LEG_B;
    end else begin
      load = 1'b1;
      leg  = ~sl;
    end
  end

endmodule

// File: rtl/hbseq_cell.sv
module hbseq_cell
  import hbseq_pkg::*;
#(
  parameter int DTW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           fire,
  input  logic           leg,
  input  logic [DTW-1:0] dead_time,
  output logic [3:0]     gate,
  output logic           up_a,
  output logic           up_b,
  output logic           last_leg
);

  logic           pa_q, pa_d, pb_q, pb_d;
  logic           last_q, last_d;
  logic [DTW-1:0] dcnt_q, dcnt_d;
  logic           dleg_q, dleg_d;
  logic           off_a, off_b;

  always_comb begin
    pa_d   = pa_q;
    pb_d   = pb_q;
    last_d = last_q;
    dcnt_d = dcnt_q;
    dleg_d = dleg_q;
    if (fire) begin
      if (leg == LEG_B) pb_d = ~pb_q;
      else              pa_d = ~pa_q;
      last_d = leg;
      dleg_d = leg;
      dcnt_d = dead_time;
    end else if (dcnt_q != '0) begin
      dcnt_d = dcnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa_q   <= 1'b0;
      pb_q   <= 1'b0;
      last_q <= LEG_A;
      dcnt_q <= '0;
      dleg_q <= LEG_A;
    end else begin
      pa_q   <= pa_d;
      pb_q   <= pb_d;
      last_q <= last_d;
      dcnt_q <= dcnt_d;
      dleg_q <= dleg_d;
    end
  end

  assign off_a = (dcnt_q != '0) && (dleg_q == LEG_A);
  assign off_b = (dcnt_q != '0) && (dleg_q == LEG_B);

  assign gate[0] =  pa_q & ~off_a;
  assign gate[1] = ~pa_q & ~off_a;
  assign gate[2] =  pb_q & ~off_b;
  assign gate[3] = ~pb_q & ~off_b;

  assign up_a     = pa_q;
  assign up_b     = pb_q;
  assign last_leg = last_q;

endmodule

// File: rtl/hb_leg_sequencer.sv
module hb_leg_sequencer
  import hbseq_pkg::*;
#(
  parameter int NCELL = 3,
  parameter int TW    = 16,
  parameter int DTW   = 8,
  localparam int CW   = (NCELL > 1) ? $clog2(NCELL) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic [CW-1:0]      cmd_cell,
  input  logic [1:0]         cmd_state,
  input  logic [TW-1:0]      cmd_instant,
  input  logic [DTW-1:0]     dead_time,
  output logic [4*NCELL-1:0] gate,
  output logic [2*NCELL-1:0] cell_state,
  output logic               cmd_err
);

  logic [NCELL-1:0] up_a, up_b, last_leg, fire_vec;
  logic             reject, load, sel_leg, fire;
  logic [CW-1:0]    pcell_q, pcell_d;
  logic             pleg_q, pleg_d;
  logic             err_q, err_d;

  hbseq_cmd_check #(.NCELL(NCELL), .CW(CW)) u_check (
    .cmd_cell (cmd_cell),
    .cmd_state(cmd_state),
    .up_a     (up_a),
    .up_b     (up_b),
    .last_leg (last_leg),
    .reject   (reject),
    .load     (load),
    .leg      (sel_leg)
  );

  hbseq_timer #(.TW(TW)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .load   (load),
    .instant(cmd_instant),
    .fire   (fire)
  );

  always_comb begin
    pcell_d = pcell_q;
    pleg_d  = pleg_q;
    err_d   = err_q;
    if (tick) begin
      err_d = reject;
      if (load) begin
        pcell_d = cmd_cell;
        pleg_d  = sel_leg;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcell_q <= '0;
      pleg_q  <= LEG_A;
      err_q   <= 1'b0;
    end else begin
      pcell_q <= pcell_d;
      pleg_q  <= pleg_d;
      err_q   <= err_d;
    end
  end

  assign cmd_err = err_q;

  for (genvar i = 0; i < NCELL; i++) begin : g_cell
    assign fire_vec[i] = fire && (pcell_q == CW'(i));

    hbseq_cell #(.DTW(DTW)) u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .fire     (fire_vec[i]),
      .leg      (pleg_q),
      .dead_time(dead_time),
      .gate     (gate[4*i +: 4]),
      .up_a     (up_a[i]),
      .up_b     (up_b[i]),
      .last_leg (last_leg[i])
    );

    assign cell_state[2*i +: 2] = legs_to_level(up_a[i], up_b[i]);
  end

endmodule

// File: rtl/hb_leg_sequencer_chk.sv
module hb_leg_sequencer_chk #(
  parameter int NCELL = 3,
  parameter int DTW   = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tick,
  input logic [DTW-1:0]     dead_time,
  input logic [4*NCELL-1:0] gate,
  input logic [2*NCELL-1:0] cell_state,
  input logic               cmd_err
);

  // R5: at most one switch turns off on any edge
  p_single_turnoff_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones($past(gate) & ~gate) <= 1);

  // R8: the error flag only changes after a capture edge
  p_err_on_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cmd_err));

  for (genvar i = 0; i < NCELL; i++) begin : g_cell_chk
    // R10: no shoot-through on leg A or leg B
    p_no_shoot_a_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate[4*i] && gate[4*i+1]));
    p_no_shoot_b_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate[4*i+2] && gate[4*i+3]));

    // R4: with a dead time, an upper switch turns on only after its lower one was off
    p_dead_gap_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(gate[4*i]) && dead_time != '0) |-> !$past(gate[4*i+1]));
    p_dead_gap_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(gate[4*i+2]) && dead_time != '0) |-> !$past(gate[4*i+3]));

    // R8: a cell never jumps across zero in one step
    p_adjacent_pos_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cell_state[2*i +: 2]) == 2'b01 |-> cell_state[2*i +: 2] != 2'b11);
    p_adjacent_neg_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cell_state[2*i +: 2]) == 2'b11 |-> cell_state[2*i +: 2] != 2'b01);
  end

endmodule

bind hb_leg_sequencer hb_leg_sequencer_chk #(.NCELL(NCELL), .DTW(DTW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .dead_time (dead_time),
  .gate      (gate),
  .cell_state(cell_state),
  .cmd_err   (cmd_err)
);

// File: tb/sim_hb_leg_sequencer.sv
module sim_hb_leg_sequencer;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick;
  logic [1:0]  cmd_cell;
  logic [1:0]  cmd_state;
  logic [15:0] cmd_instant;
  logic [7:0]  dead_time;
  logic [11:0] gate;
  logic [5:0]  cell_state;
  logic        cmd_err;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  hb_leg_sequencer u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cmd_cell(cmd_cell),
    .cmd_state(cmd_state), .cmd_instant(cmd_instant), .dead_time(dead_time),
    .gate(gate), .cell_state(cell_state), .cmd_err(cmd_err)
  );

  // {cell, level, instant, expected gates, expected err}
  localparam int NV = 14;
  localparam logic [24:0] VEC [NV] = '{
    {2'd0, 2'b01, 8'd3, 12'hAA9, 1'b0},  // R7 from both-lower, +1 moves A
    {2'd0, 2'b00, 8'd0, 12'hAA5, 1'b0},  // R6 back to zero moves B
    {2'd1, 2'b11, 8'd5, 12'hA65, 1'b0},  // R7 R5 other cell untouched
    {2'd0, 2'b11, 8'd2, 12'hA66, 1'b0},  // R7 from both-upper, -1 moves A
    {2'd1, 2'b01, 8'd4, 12'hA66, 1'b1},  // R8 -1 to +1 refused
    {2'd2, 2'b10, 8'd1, 12'hA66, 1'b1},  // R8 unused code refused
    {2'd3, 2'b01, 8'd1, 12'hA66, 1'b1},  // R8 cell out of range refused
    {2'd0, 2'b00, 8'd7, 12'hA6A, 1'b0},  // R6 last was A, so B moves
    {2'd1, 2'b00, 8'd2, 12'hA5A, 1'b0},  // R6 last was B, so A moves
    {2'd1, 2'b01, 8'd4, 12'hA9A, 1'b0},  // R7 from both-upper, +1 moves B
    {2'd1, 2'b01, 8'd6, 12'hA9A, 1'b0},  // R9 same level, no change
    {2'd1, 2'b00, 8'd1, 12'hAAA, 1'b0},  // R6 last was B, so A moves
    {2'd2, 2'b11, 8'd9, 12'h6AA, 1'b0},  // R7 from both-lower, -1 moves B
    {2'd2, 2'b00, 8'd0, 12'h5AA, 1'b0}   // R6 R3 instant zero
  };

  function automatic logic [1:0] nib_level(input logic [3:0] n);
    case (n)
      4'b1001: return 2'b01;
      4'b0110: return 2'b11;
      default: return 2'b00;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Issue one command on a tick, leave the bench at the negedge after the capture edge.
  task automatic issue(input logic [1:0] c, input logic [1:0] s, input logic [15:0] t);
    @(negedge clk);
    cmd_cell = c; cmd_state = s; cmd_instant = t; tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick = 1'b0; cmd_cell = '0; cmd_state = '0;
    cmd_instant = '0; dead_time = 8'd2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 gates after reset", gate, 12'hAAA);
    check("R1 state after reset", cell_state, 6'h0);
    check("R1 err after reset", cmd_err, 1'b0);

    for (int k = 0; k < NV; k++) begin
      logic [5:0] st;
      issue(VEC[k][24:23], VEC[k][22:21], {8'd0, VEC[k][20:13]});
      repeat (18) @(negedge clk);
      check($sformatf("R2/R5-R9 vector %0d gates", k), gate, VEC[k][12:1]);
      check($sformatf("R8/R9 vector %0d err", k), cmd_err, VEC[k][0]);
      for (int c = 0; c < 3; c++) st[2*c +: 2] = nib_level(VEC[k][1 + 4*c +: 4]);
      check($sformatf("R2 vector %0d state", k), cell_state, st);
    end

    // R3 R4: cell 2 from both-upper to +1 moves B, instant 4, dead time 2
    issue(2'd2, 2'b01, 16'd4);
    repeat (4) @(negedge clk);
    check("R3 before instant", gate[11:8], 4'b0101);
    @(negedge clk);
    check("R4 dead gap cycle 1", gate[11:8], 4'b0001);
    @(negedge clk);
    check("R4 dead gap cycle 2", gate[11:8], 4'b0001);
    @(negedge clk);
    check("R4 complement on", gate[11:8], 4'b1001);
    check("R5 other cells kept", gate[7:0], 8'hAA);
    repeat (10) @(negedge clk);

    // R3: instant 0 acts on the first edge; cell 2 back to zero moves A
    issue(2'd2, 2'b00, 16'd0);
    check("R3 instant zero before first edge", gate[11:8], 4'b1001);
    @(negedge clk);
    check("R3 instant zero first edge", gate[11:8], 4'b1000);
    repeat (4) @(negedge clk);
    check("R3 instant zero settled", gate[11:8], 4'b1010);

    // R4: zero dead time, cell 2 both-lower to -1 moves B at instant 2
    dead_time = 8'd0;
    issue(2'd2, 2'b11, 16'd2);
    repeat (2) @(negedge clk);
    check("R3 zero dead time before", gate[11:8], 4'b1010);
    @(negedge clk);
    check("R4 zero dead time immediate", gate[11:8], 4'b0110);
    check("R2 state negative", cell_state[5:4], 2'b11);
    repeat (6) @(negedge clk);

    // R1: reset mid-run restores the idle pattern
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 gates after second reset", gate, 12'hAAA);
    check("R1 state after second reset", cell_state, 6'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule